// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between a host bus and a flash array. It sees each host write as a single-cycle strobe that carries an address and a 16-bit word. The strobe stands for the rising edge of write enable. The low byte of the word is decoded as a command. Some commands act in one cycle: they select what reads return, or they clear the status. Others are two-cycle sequences: erase, word write and lock configuration. Each of these needs a confirm code or a data word in its second cycle.

When a sequence is accepted, the block runs an internal operation for a fixed number of clock cycles, which differs by kind of operation. During that time it drives a ready/busy line low and reports progress through an 8-bit status word.

Running erases and word writes can be suspended and resumed. While an erase is suspended, one word write may run inside it. Errors stay latched until the host clears them. A sequence is rejected before any busy time when any of these holds:
- the external permission flag is low;
- the supply-good flag is low;
- a stored permanent lock forbids the operation.

The array itself is outside the block. For each launched operation the block presents the latched target address and data word, and it tells the read path which source to return:
- array data;
- identification data, which the block supplies;
- the status word, which the block supplies.

Top module: `fcc_ctrl`

## Requirements
- R1: After reset, reads select the array (`rd_src_o` = 0), `rdy_o` = 1, `rdy_en_o` = 1, the status word reads 0080h and the permanent lock reads 0.
- R2: Low byte FFh selects array reads (source 0). 90h selects identification reads (source 1): address 0 returns 00B0h, address 1 returns 00E9h, address 3 returns the permanent lock in bit 0, and any other address returns 0000h. 70h selects status reads (source 2, word = {8'h00, status}). Unrecognised codes while idle change nothing.
- R3: The following sequences start an operation that keeps `rdy_o` low and status bit 7 at 0 for exactly the stated number of cycles after the edge that accepts the second write:
  - 20h then D0h (block erase): ERASE_CYC;
  - 30h then D0h (full erase): ERASE_CYC;
  - 40h or 10h then a data word (word write): WRITE_CYC;
  - 60h then 01h (set block lock): LOCK_CYC;
  - 60h then D0h (clear block locks): LOCK_CYC;
  - 60h then F1h (set permanent lock): LOCK_CYC.
- R4: While an operation runs, reads return the status word whatever the selected mode, and every write except B0h is ignored.
- R5: B0h during a running erase or word write suspends it. While suspended:
  - `rdy_en_o` = 0 (the line floats);
  - status bit 7 = 1;
  - status bit 6 = 1 for an erase, or status bit 2 = 1 for a word write;
  - the remaining time is frozen, and the read-mode commands still work.
  
  D0h resumes the operation for the remaining cycles.
- R6: While an erase is suspended, 40h/10h and a data word run a word write for WRITE_CYC cycles. During it `rdy_o` = 0 (driven) and status bit 6 stays 1. Afterwards the erase is suspended again.
- R7: After 20h, 30h or 60h, a second code that is not a valid confirm sets status bits 5 and 4, starts nothing, and returns reads to the array.
- R8: With `allow_i` low (and supply good) when a sequence completes, the operation aborts without busy time. It sets status bit 1 plus bit 5 (erases, clear block locks) or bit 4 (word write, set block lock, set permanent lock).
- R9: With `vpp_ok_i` low when a sequence completes, the operation aborts without busy time. It sets status bit 3 plus the same bit 5 or bit 4, and does not set bit 1.
- R10: Status bits 5, 4, 3 and 1 stay set across later operations until 50h clears them. Status bit 0 always reads 0.
- R11: Once the permanent lock is set, set-block-lock and clear-block-locks abort as in R8 even with `allow_i` high.
- R12: Completing, aborting or starting any operation selects status reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb_i | input | 1 | One-cycle host write strobe |
| wr_addr_i | input | ADDR_W | Host write address |
| wr_data_i | input | 16 | Host write word; low byte is the command code |
| rd_addr_i | input | ADDR_W | Host read address |
| allow_i | input | 1 | Protection decode permits the operation |
| vpp_ok_i | input | 1 | Program/erase supply is within range |
| rd_src_o | output | 2 | Read source: 0 array, 1 identification, 2 status |
| rd_word_o | output | 16 | Read word for identification/status sources, 0 for array |
| rdy_o | output | 1 | Ready/busy level, 0 while an operation runs |
| rdy_en_o | output | 1 | Ready/busy drive enable, 0 means high-impedance |
| op_addr_o | output | ADDR_W | Target address latched at the last launch |
| op_data_o | output | 16 | Data word latched at the last launch |

## Verification
A wrong sequencer state appears at the ports within one cycle. Depending on the state, it shows as:
- a read source or status word that differs from the command history;
- a ready/busy level or enable that differs from that history.

A timer that is off by one, or that keeps counting while suspended, shows only when the operation ends. The bench therefore checks `rdy_o` both on the last busy cycle and on the first ready cycle after every launch, resume and nested write. Latched error bits stay visible in the status word until the clear command, so a lost or spurious bit shows on the next status read.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    typedef enum logic [1:0] {
        SRC_ARRAY  = 2'd0,
        SRC_IDENT  = 2'd1,
        SRC_STATUS = 2'd2
    } rd_src_e;

    typedef enum logic [3:0] {
        CMD_NONE,
        CMD_RD_ARRAY,
        CMD_RD_IDENT,
        CMD_RD_STATUS,
        CMD_CLR_STATUS,
        CMD_ERASE_BLK,
        CMD_ERASE_ALL,
        CMD_WRITE,
        CMD_SUSPEND,
        CMD_CONFIRM,
        CMD_LOCK,
        CMD_LOCK_SET,
        CMD_LOCK_PERM
    } cmd_e;

    typedef enum logic [2:0] {
        ST_READY,
        ST_ARM,
        ST_BUSY,
        ST_SUSP,
        ST_ARM_S,
        ST_NEST
    } st_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ERASE_BLK,
        OP_ERASE_ALL,
        OP_WRITE,
        OP_LOCK_SET,
        OP_LOCK_CLR,
        OP_LOCK_PERM
    } op_e;

    localparam logic [7:0] CODE_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] CODE_RD_IDENT  = 8'h90;
    localparam logic [7:0] CODE_RD_STATUS = 8'h70;
    localparam logic [7:0] CODE_CLR       = 8'h50;
    localparam logic [7:0] CODE_ERASE_BLK = 8'h20;
    localparam logic [7:0] CODE_ERASE_ALL = 8'h30;
    localparam logic [7:0] CODE_WRITE_A   = 8'h40;
    localparam logic [7:0] CODE_WRITE_B   = 8'h10;
    localparam logic [7:0] CODE_SUSPEND   = 8'hB0;
    localparam logic [7:0] CODE_CONFIRM   = 8'hD0;
    localparam logic [7:0] CODE_LOCK      = 8'h60;
    localparam logic [7:0] CODE_LOCK_SET  = 8'h01;
    localparam logic [7:0] CODE_LOCK_PERM = 8'hF1;

    localparam logic [7:0] ID_MAKER  = 8'hB0;
    localparam logic [7:0] ID_DEVICE = 8'hE9;

    // Erase-class operations report failure in status bit 5, the rest in bit 4.
    function automatic logic op_erase_class(input op_e op);
        return (op == OP_ERASE_BLK) || (op == OP_ERASE_ALL) || (op == OP_LOCK_CLR);
    endfunction

endpackage

// File: rtl/fcc_decode.sv
module fcc_decode
    import fcc_pkg::*;
(
    input  logic [7:0] code_i,
    output cmd_e       cmd_o
);

    always_comb begin
        case (code_i)
            CODE_RD_ARRAY:  cmd_o = CMD_RD_ARRAY;
            CODE_RD_IDENT:  cmd_o = CMD_RD_IDENT;
            CODE_RD_STATUS: cmd_o = CMD_RD_STATUS;
            CODE_CLR:       cmd_o = CMD_CLR_STATUS;
            CODE_ERASE_BLK: cmd_o = CMD_ERASE_BLK;
            CODE_ERASE_ALL: cmd_o = CMD_ERASE_ALL;
            CODE_WRITE_A,
            CODE_WRITE_B:   cmd_o = CMD_WRITE;
            CODE_SUSPEND:   cmd_o = CMD_SUSPEND;
            CODE_CONFIRM:   cmd_o = CMD_CONFIRM;
            CODE_LOCK:      cmd_o = CMD_LOCK;
            CODE_LOCK_SET:  cmd_o = CMD_LOCK_SET;
            CODE_LOCK_PERM: cmd_o = CMD_LOCK_PERM;
            default:        cmd_o = CMD_NONE;
        endcase
    end

endmodule

// File: rtl/fcc_timer.sv
module fcc_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    output logic             last_o,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = run_i && (cnt_q == CNT_W'(1));
    assign cnt_o  = cnt_q;

    AST_TMR_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q != '0)); // R3

endmodule

// File: rtl/fcc_rdmux.sv
module fcc_rdmux
    import fcc_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  rd_src_e           mode_i,
    input  logic              busy_i,
    input  logic [7:0]        sr_i,
    input  logic              perm_i,
    input  logic [ADDR_W-1:0] addr_i,
    output rd_src_e           src_o,
    output logic [15:0]       word_o
);

    localparam logic [ADDR_W-1:0] A_MAKER  = '0;
    localparam logic [ADDR_W-1:0] A_DEVICE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_PERM   = ADDR_W'(3);

    always_comb begin
        src_o  = busy_i ? SRC_STATUS : mode_i;
        word_o = 16'h0000;
        case (src_o)
            SRC_STATUS: word_o = {8'h00, sr_i};
            SRC_IDENT: begin
                if (addr_i == A_MAKER)       word_o = {8'h00, ID_MAKER};
                else if (addr_i == A_DEVICE) word_o = {8'h00, ID_DEVICE};
                else if (addr_i == A_PERM)   word_o = {15'h0000, perm_i};
                else                         word_o = 16'h0000;
            end
            default: word_o = 16'h0000;
        endcase
    end

endmodule

// File: rtl/fcc_ctrl.sv
module fcc_ctrl
    import fcc_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int ERASE_CYC = 64,
    parameter int WRITE_CYC = 16,
    parameter int LOCK_CYC  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [15:0]       wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              allow_i,
    input  logic              vpp_ok_i,
    output logic [1:0]        rd_src_o,
    output logic [15:0]       rd_word_o,
    output logic              rdy_o,
    output logic              rdy_en_o,
    output logic [ADDR_W-1:0] op_addr_o,
    output logic [15:0]       op_data_o
);

    localparam int MAX_EW = (ERASE_CYC > WRITE_CYC) ? ERASE_CYC : WRITE_CYC;
    localparam int MAX_C  = (MAX_EW > LOCK_CYC) ? MAX_EW : LOCK_CYC;
    localparam int CNT_W  = $clog2(MAX_C + 1);

    typedef struct packed {
        st_e               st;
        cmd_e              pend;
        op_e               op;
        rd_src_e           rmode;
        logic              e_era;
        logic              e_wr;
        logic              e_vpp;
        logic              e_prot;
        logic              perm;
        logic [ADDR_W-1:0] addr;
        logic [15:0]       data;
    } ctl_t;

    ctl_t q, d;

    cmd_e             cmd;
    logic             t_load, t_last, t_run;
    logic             n_load, n_last, n_run;
    logic [CNT_W-1:0] t_val, t_cnt, n_cnt;
    logic             launch, nested, prot_fail;
    op_e              l_op;
    logic             busy, susp;
    logic [7:0]       sr;
    rd_src_e          src;

    fcc_decode u_dec (
        .code_i (wr_data_i[7:0]),
        .cmd_o  (cmd)
    );

    function automatic logic [CNT_W-1:0] op_len(input op_e op);
        case (op)
            OP_ERASE_BLK,
            OP_ERASE_ALL: return CNT_W'(ERASE_CYC);
            OP_WRITE:     return CNT_W'(WRITE_CYC);
            default:      return CNT_W'(LOCK_CYC);
        endcase
    endfunction

    always_comb begin
        d         = q;
        t_load    = 1'b0;
        t_val     = '0;
        n_load    = 1'b0;
        launch    = 1'b0;
        l_op      = OP_NONE;
        nested    = 1'b0;
        prot_fail = 1'b0;

        case (q.st)
            ST_READY: begin
                if (wr_stb_i) begin
                    case (cmd)
                        CMD_RD_ARRAY:  d.rmode = SRC_ARRAY;
                        CMD_RD_IDENT:  d.rmode = SRC_IDENT;
                        CMD_RD_STATUS: d.rmode = SRC_STATUS;
                        CMD_CLR_STATUS: begin
                            d.e_era  = 1'b0;
                            d.e_wr   = 1'b0;
                            d.e_vpp  = 1'b0;
                            d.e_prot = 1'b0;
                        end
                        CMD_ERASE_BLK, CMD_ERASE_ALL, CMD_WRITE, CMD_LOCK: begin
                            d.st    = ST_ARM;
                            d.pend  = cmd;
                            d.rmode = SRC_STATUS;
                        end
                        default: ;
                    endcase
                end
            end
            ST_ARM: begin
                if (wr_stb_i) begin
                    case (q.pend)
                        CMD_WRITE:     l_op = OP_WRITE;
                        CMD_ERASE_BLK: if (cmd == CMD_CONFIRM) l_op = OP_ERASE_BLK;
                        CMD_ERASE_ALL: if (cmd == CMD_CONFIRM) l_op = OP_ERASE_ALL;
                        CMD_LOCK: begin
                            if (cmd == CMD_LOCK_SET)       l_op = OP_LOCK_SET;
                            else if (cmd == CMD_CONFIRM)   l_op = OP_LOCK_CLR;
                            else if (cmd == CMD_LOCK_PERM) l_op = OP_LOCK_PERM;
                        end
                        default: ;
                    endcase
                    if (l_op == OP_NONE) begin
                        d.e_era = 1'b1;
                        d.e_wr  = 1'b1;
                        d.st    = ST_READY;
                        d.rmode = SRC_ARRAY;
                    end else begin
                        launch = 1'b1;
                    end
                end
            end
            ST_BUSY: begin
                if (t_last) begin
                    d.st = ST_READY;
                    if (q.op == OP_LOCK_PERM) d.perm = 1'b1;
                end else if (wr_stb_i && (cmd == CMD_SUSPEND) &&
                             (q.op inside {OP_ERASE_BLK, OP_ERASE_ALL, OP_WRITE})) begin
                    d.st = ST_SUSP;
                end
            end
            ST_SUSP: begin
                if (wr_stb_i) begin
                    case (cmd)
                        CMD_CONFIRM: begin
                            d.st    = ST_BUSY;
                            d.rmode = SRC_STATUS;
                        end
                        CMD_RD_ARRAY:  d.rmode = SRC_ARRAY;
                        CMD_RD_IDENT:  d.rmode = SRC_IDENT;
                        CMD_RD_STATUS: d.rmode = SRC_STATUS;
                        CMD_CLR_STATUS: begin
                            d.e_era  = 1'b0;
                            d.e_wr   = 1'b0;
                            d.e_vpp  = 1'b0;
                            d.e_prot = 1'b0;
                        end
                        CMD_WRITE: begin
                            if (q.op inside {OP_ERASE_BLK, OP_ERASE_ALL}) begin
                                d.st    = ST_ARM_S;
                                d.rmode = SRC_STATUS;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_ARM_S: begin
                if (wr_stb_i) begin
                    l_op   = OP_WRITE;
                    launch = 1'b1;
                    nested = 1'b1;
                end
            end
            ST_NEST: begin
                if (n_last) d.st = ST_SUSP;
            end
            default: d.st = ST_READY;
        endcase

        if (launch) begin
            d.rmode   = SRC_STATUS;
            d.addr    = wr_addr_i;
            d.data    = wr_data_i;
            prot_fail = !allow_i ||
                        (q.perm && ((l_op == OP_LOCK_SET) || (l_op == OP_LOCK_CLR)));
            if (!vpp_ok_i || prot_fail) begin
                if (!vpp_ok_i) d.e_vpp  = 1'b1;
                else           d.e_prot = 1'b1;
                if (op_erase_class(l_op)) d.e_era = 1'b1;
                else                      d.e_wr  = 1'b1;
                d.st = nested ? ST_SUSP : ST_READY;
            end else if (nested) begin
                d.st   = ST_NEST;
                n_load = 1'b1;
            end else begin
                d.st   = ST_BUSY;
                d.op   = l_op;
                t_load = 1'b1;
                t_val  = op_len(l_op);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign t_run = (q.st == ST_BUSY);
    assign n_run = (q.st == ST_NEST);

    fcc_timer #(.CNT_W(CNT_W)) u_main_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (t_load),
        .load_val_i (t_val),
        .run_i      (t_run),
        .last_o     (t_last),
        .cnt_o      (t_cnt)
    );

    fcc_timer #(.CNT_W(CNT_W)) u_nest_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (n_load),
        .load_val_i (CNT_W'(WRITE_CYC)),
        .run_i      (n_run),
        .last_o     (n_last),
        .cnt_o      (n_cnt)
    );

    assign busy = (q.st == ST_BUSY) || (q.st == ST_NEST);
    assign susp = (q.st == ST_SUSP) || (q.st == ST_ARM_S) || (q.st == ST_NEST);

    assign sr = {!busy,
                 susp && (q.op inside {OP_ERASE_BLK, OP_ERASE_ALL}),
                 q.e_era,
                 q.e_wr,
                 q.e_vpp,
                 susp && (q.op == OP_WRITE),
                 q.e_prot,
                 1'b0};

    fcc_rdmux #(.ADDR_W(ADDR_W)) u_rdmux (
        .mode_i (q.rmode),
        .busy_i (busy),
        .sr_i   (sr),
        .perm_i (q.perm),
        .addr_i (rd_addr_i),
        .src_o  (src),
        .word_o (rd_word_o)
    );

    assign rd_src_o  = src;
    assign rdy_o     = !busy;
    assign rdy_en_o  = !((q.st == ST_SUSP) || (q.st == ST_ARM_S));
    assign op_addr_o = q.addr;
    assign op_data_o = q.data;

    logic [3:0] err_q;
    assign err_q = {q.e_era, q.e_wr, q.e_vpp, q.e_prot};

    AST_BUSY_READS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_en_o && !rdy_o) |-> (rd_src_o == SRC_STATUS)); // R4

    AST_SUSP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_en_o) |-> (rd_word_o[7] || (rd_src_o != SRC_STATUS))); // R5

    AST_SUSP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_SUSP) && $past(q.st == ST_SUSP)) |-> $stable(t_cnt)); // R5

    AST_NEST_KEEPS_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_NEST) |-> sr[6]); // R6

    AST_NEST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.st == ST_NEST) |-> (n_cnt == CNT_W'(WRITE_CYC))); // R6

    AST_IMPROPER: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_ARM) && wr_stb_i && (q.pend != CMD_WRITE) && !launch)
        |=> (sr[5] && sr[4] && rdy_o && (rd_src_o == SRC_ARRAY))); // R7

    AST_PROT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_ARM) && launch && vpp_ok_i && !allow_i) |=> (rdy_o && sr[1])); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb_i && (cmd == CMD_CLR_STATUS)) |=> ((err_q & $past(err_q)) == $past(err_q))); // R10

endmodule

// File: tb/tb_fcc_ctrl.sv
module tb_fcc_ctrl;

    localparam int EC = 10;
    localparam int WC = 4;
    localparam int LC = 3;
    localparam int NV = 33;

    // Vector fields: [46] 0=write 1=read-check, [45:38] address, [37:22] write word,
    // [21:20] expected source, [19:4] expected read word, [3:0] requirement number.
    localparam logic [46:0] VEC [NV] = '{
        {1'b1, 8'h00, 16'h0000, 2'd0, 16'h0000, 4'd1},  // R1 reset selects array
        {1'b0, 8'h00, 16'h0090, 2'd0, 16'h0000, 4'd2},
        {1'b1, 8'h00, 16'h0000, 2'd1, 16'h00B0, 4'd2},  // R2 maker code
        {1'b1, 8'h01, 16'h0000, 2'd1, 16'h00E9, 4'd2},  // R2 device code
        {1'b1, 8'h03, 16'h0000, 2'd1, 16'h0000, 4'd1},  // R1 permanent lock clear
        {1'b1, 8'h02, 16'h0000, 2'd1, 16'h0000, 4'd2},  // R2 other address
        {1'b0, 8'h00, 16'h0070, 2'd0, 16'h0000, 4'd2},
        {1'b1, 8'h00, 16'h0000, 2'd2, 16'h0080, 4'd1},  // R1 idle status 80h
        {1'b0, 8'h00, 16'h00FF, 2'd0, 16'h0000, 4'd2},
        {1'b1, 8'h00, 16'h0000, 2'd0, 16'h0000, 4'd2},  // R2 back to array
        {1'b0, 8'h00, 16'h00D0, 2'd0, 16'h0000, 4'd2},
        {1'b1, 8'h00, 16'h0000, 2'd0, 16'h0000, 4'd2},  // R2 lone confirm ignored
        {1'b0, 8'h00, 16'h0020, 2'd0, 16'h0000, 4'd7},
        {1'b0, 8'h00, 16'h0055, 2'd0, 16'h0000, 4'd7},
        {1'b1, 8'h00, 16'h0000, 2'd0, 16'h0000, 4'd7},  // R7 improper erase -> array
        {1'b0, 8'h00, 16'h0070, 2'd0, 16'h0000, 4'd7},
        {1'b1, 8'h00, 16'h0000, 2'd2, 16'h00B0, 4'd7},  // R7 bits 5 and 4
        {1'b0, 8'h00, 16'h0050, 2'd0, 16'h0000, 4'd10},
        {1'b1, 8'h00, 16'h0000, 2'd2, 16'h0080, 4'd10}, // R10 clear
        {1'b0, 8'h00, 16'h0060, 2'd0, 16'h0000, 4'd7},
        {1'b0, 8'h00, 16'h0077, 2'd0, 16'h0000, 4'd7},
        {1'b1, 8'h00, 16'h0000, 2'd0, 16'h0000, 4'd7},  // R7 improper lock -> array
        {1'b0, 8'h00, 16'h0070, 2'd0, 16'h0000, 4'd7},
        {1'b1, 8'h00, 16'h0000, 2'd2, 16'h00B0, 4'd7},  // R7
        {1'b0, 8'h00, 16'h0050, 2'd0, 16'h0000, 4'd10},
        {1'b0, 8'h00, 16'h0030, 2'd0, 16'h0000, 4'd7},
        {1'b0, 8'h00, 16'h00FF, 2'd0, 16'h0000, 4'd7},
        {1'b0, 8'h00, 16'h0070, 2'd0, 16'h0000, 4'd7},
        {1'b1, 8'h00, 16'h0000, 2'd2, 16'h00B0, 4'd7},  // R7 improper full erase
        {1'b0, 8'h00, 16'h0050, 2'd0, 16'h0000, 4'd10},
        {1'b1, 8'h00, 16'h0000, 2'd2, 16'h0080, 4'd10}, // R10
        {1'b0, 8'h00, 16'h00FF, 2'd0, 16'h0000, 4'd2},
        {1'b1, 8'h00, 16'h0000, 2'd0, 16'h0000, 4'd2}   // R2
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [19:0] rd_addr = '0;
    logic [15:0] wr_data = '0;
    logic        allow = 1'b1;
    logic        vpp = 1'b1;
    logic [1:0]  rd_src;
    logic [15:0] rd_word;
    logic        rdy, rdy_en;
    logic [19:0] op_addr;
    logic [15:0] op_data;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    fcc_ctrl #(.ADDR_W(20), .ERASE_CYC(EC), .WRITE_CYC(WC), .LOCK_CYC(LC)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb_i  (wr_stb),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .allow_i   (allow),
        .vpp_ok_i  (vpp),
        .rd_src_o  (rd_src),
        .rd_word_o (rd_word),
        .rdy_o     (rdy),
        .rdy_en_o  (rdy_en),
        .op_addr_o (op_addr),
        .op_data_o (op_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Every task starts and ends just after a falling edge.
    task automatic wr(input logic [19:0] a, input logic [15:0] dw);
        wr_addr = a;
        wr_data = dw;
        wr_stb  = 1'b1;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic status_is(input string tag, input logic [15:0] exp);
        rd_addr = '0;
        #1;
        chk({tag, " source"}, {30'd0, rd_src}, 32'd2);
        chk({tag, " word"}, {16'd0, rd_word}, {16'd0, exp});
    endtask

    task automatic busy_for(input string tag, input int n);
        idle(n - 1);
        chk({tag, " last busy cycle"}, {31'd0, rdy}, 32'd0);
        idle(1);
        chk({tag, " ready after"}, {31'd0, rdy}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [46:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk("R1 rdy after reset", {31'd0, rdy}, 32'd1);
        chk("R1 rdy_en after reset", {31'd0, rdy_en}, 32'd1);

        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            if (!v[46]) begin
                wr({12'd0, v[45:38]}, v[37:22]);
            end else begin
                rd_addr = {12'd0, v[45:38]};
                #1;
                chk($sformatf("R%0d vector %0d source", v[3:0], i), {30'd0, rd_src}, {30'd0, v[21:20]});
                chk($sformatf("R%0d vector %0d word", v[3:0], i), {16'd0, rd_word}, {16'd0, v[19:4]});
            end
        end

        // R3 R12: word write from array mode, busy WC cycles, then status selected
        wr(20'h01234, 16'h0040);
        wr(20'h01234, 16'hBEEF);
        chk("R3 write busy", {31'd0, rdy}, 32'd0);
        status_is("R3 write status while busy", 16'h0000);
        chk("R3 latched address", {12'd0, op_addr}, 32'h01234);
        chk("R3 latched data", {16'd0, op_data}, 32'hBEEF);
        busy_for("R3 write", WC);
        status_is("R12 status after write", 16'h0080);

        // R4: block erase, array-read command ignored while busy
        wr(20'h08000, 16'h0020);
        wr(20'h08000, 16'h00D0);
        wr(20'h00000, 16'h00FF);
        status_is("R4 reads status while busy", 16'h0000);
        busy_for("R3 block erase", EC - 1);
        status_is("R4 ignored read-array while busy", 16'h0080);

        // R5: erase suspend freezes remaining time, read array while suspended
        wr(20'h08000, 16'h0020);
        wr(20'h08000, 16'h00D0);
        idle(3);
        wr(20'h0, 16'h00B0);
        chk("R5 erase suspend floats line", {31'd0, rdy_en}, 32'd0);
        status_is("R5 erase suspend status", 16'h00C0);
        idle(5);
        status_is("R5 still suspended", 16'h00C0);
        wr(20'h0, 16'h00FF);
        rd_addr = '0;
        #1;
        chk("R5 array read during suspend", {30'd0, rd_src}, 32'd0);
        wr(20'h0, 16'h00D0);
        chk("R5 resume drives line", {31'd0, rdy_en}, 32'd1);
        busy_for("R5 erase remaining", 6);
        status_is("R5 after resume", 16'h0080);

        // R6: word write nested inside suspended full erase
        wr(20'h0, 16'h0030);
        wr(20'h0, 16'h00D0);
        wr(20'h0, 16'h00B0);
        wr(20'h00010, 16'h0010);
        wr(20'h00010, 16'h5A5A);
        chk("R6 nested write drives line", {31'd0, rdy_en}, 32'd1);
        status_is("R6 nested status", 16'h0040);
        idle(WC - 1);
        chk("R6 nested last busy", {31'd0, rdy}, 32'd0);
        idle(1);
        chk("R6 back to suspended", {31'd0, rdy_en}, 32'd0);
        status_is("R6 erase still suspended", 16'h00C0);
        wr(20'h0, 16'h00D0);
        busy_for("R6 erase remaining", EC - 1);

        // R5: word write suspend and resume
        wr(20'h0, 16'h0040);
        wr(20'h0, 16'h1111);
        wr(20'h0, 16'h00B0);
        status_is("R5 write suspend status", 16'h0084);
        wr(20'h0, 16'h00D0);
        busy_for("R5 write remaining", WC - 1);

        // R8: protection abort
        allow = 1'b0;
        wr(20'h0, 16'h0020);
        wr(20'h0, 16'h00D0);
        chk("R8 erase abort no busy", {31'd0, rdy}, 32'd1);
        status_is("R8 erase protect", 16'h00A2);
        wr(20'h0, 16'h0050);
        wr(20'h0, 16'h0040);
        wr(20'h0, 16'h2222);
        status_is("R8 write protect", 16'h0092);
        wr(20'h0, 16'h0050);

        // R9: supply abort takes priority over protection
        vpp = 1'b0;
        wr(20'h0, 16'h0040);
        wr(20'h0, 16'h3333);
        chk("R9 abort no busy", {31'd0, rdy}, 32'd1);
        status_is("R9 supply error", 16'h0098);
        allow = 1'b1;
        vpp = 1'b1;

        // R10: errors survive a good operation
        wr(20'h0, 16'h0040);
        wr(20'h0, 16'h4444);
        busy_for("R10 good write", WC);
        status_is("R10 sticky", 16'h0098);
        wr(20'h0, 16'h0050);
        status_is("R10 cleared", 16'h0080);

        // R11: permanent lock
        wr(20'h0, 16'h0060);
        wr(20'h0, 16'h00F1);
        busy_for("R3 permanent lock", LC);
        wr(20'h0, 16'h0090);
        rd_addr = 20'h00003;
        #1;
        chk("R11 lock reads set", {16'd0, rd_word}, 32'd1);
        wr(20'h0, 16'h0060);
        wr(20'h0, 16'h00D0);
        chk("R11 clear locks no busy", {31'd0, rdy}, 32'd1);
        status_is("R11 clear locks aborted", 16'h00A2);
        wr(20'h0, 16'h0050);
        wr(20'h0, 16'h0060);
        wr(20'h0, 16'h0001);
        status_is("R11 set lock aborted", 16'h0092);

        // R1: reset during busy
        wr(20'h0, 16'h0050);
        wr(20'h0, 16'h0020);
        wr(20'h0, 16'h00D0);
        rst_n = 1'b0;
        idle(1);
        rst_n = 1'b1;
        idle(1);
        chk("R1 reset mid-busy ready", {31'd0, rdy}, 32'd1);
        rd_addr = '0;
        #1;
        chk("R1 reset mid-busy array", {30'd0, rd_src}, 32'd0);
        wr(20'h0, 16'h0090);
        rd_addr = 20'h00003;
        #1;
        chk("R1 reset clears lock", {16'd0, rd_word}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule